// File: doc/BRIEF.md
# Dual-Channel Edge Capture Unit

This block timestamps signal transitions for a small microcontroller timer. A 16-bit counter runs from a prescaled copy of the system clock. Each of two capture pins is synchronized and watched for one chosen transition, either rising or falling. When that transition appears, the current counter value is latched into the channel's capture register, the channel's status flag is raised, and an interrupt request may be raised too.

Software reaches the block over an 8-bit register bus. A 16-bit capture value comes out as two bytes: high byte first, then low byte. Reading the high byte freezes the register until the low byte has been accessed, so the two bytes always belong to the same capture. A capture that arrives while the register is frozen is parked in a shadow register and moves in when the low byte is accessed.

A flag is cleared by a two-step sequence. First the status register is read while the flag is set. Then the channel's low byte is accessed. While the processor is halted, a valid edge only arms the channel. The flag and the captured value appear when the halt ends.

Top module: `dual_edge_capture`

## Requirements
- R1: After reset, the counter is 0. The configuration register (address 0), the status register (address 1) and all capture bytes (addresses 2 to 5) read 0, and `irq_o` is low.
- R2: Configuration bits [5:4] select the counter rate. Value 0 advances the counter once every 4 clocks, 1 once every 2 clocks and 2 once every 8 clocks. Value 3 stops the counter. The counter never changes by more than 1 per clock.
- R3: Configuration bit c (c = 0 or 1) selects the active edge of capture pin c: 1 means rising, 0 means falling. The pin passes through two synchronizer flops. The captured value equals `count_o` as seen in the clock cycle that follows the second rising clock edge after the pin change. The opposite transition captures nothing.
- R4: A capture on channel c sets bit c of the status register.
- R5: `irq_o` is high exactly when configuration bit 2 (interrupt enable) is set, `glob_mask_i` is low and at least one status flag is set.
- R6: A flag clears only when two things happen in order. First the status register is read while that flag is set. Then the channel's low byte is read or written (address 3 for channel 0, 5 for channel 1). A low-byte access with no preceding status read leaves the flag set.
- R7: If a flag is set after the status read, the following low-byte access does not clear it.
- R8: Reading a channel's high byte (address 2 or 4) freezes that capture register. A capture that arrives while it is frozen goes into a shadow register; only the most recent one is kept. The register loads the shadow value when the low byte is accessed. The access that unfreezes the register still returns the old low byte.
- R9: While `halt_i` is high, an active edge sets no flag and no interrupt request, and changes no capture register. After `halt_i` falls, the flag is set and the register holds the counter value of the first active edge seen during the halt.
- R10: Writes to the status register or to a high byte change no register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Processor is in low-power halt |
| glob_mask_i | input | 1 | Global interrupt mask, 1 blocks the request |
| cap_pin_i | input | 2 | Asynchronous capture pins, one per channel |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Capture interrupt request |
| count_o | output | 16 | Free-running counter value |

## Verification
The bench builds the block with its default parameters: two channels, a 16-bit counter and a two-flop synchronizer. With these values both channels and all four counter rates are reachable from the bus, and the high/low byte split falls on real byte boundaries. The two-flop synchronizer gives a fixed latency from a pin change to the capture. Because that latency is known, the bench can predict each captured value by sampling the counter, and it can place captures deliberately inside the frozen window, the halt window and the gap between a status read and a low-byte access.

// File: rtl/capu_pkg.sv
package capu_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 3;

  typedef enum logic [1:0] {
    CK_DIV4 = 2'b00,
    CK_DIV2 = 2'b01,
    CK_DIV8 = 2'b10,
    CK_STOP = 2'b11
  } ck_sel_e;

  // last prescaler state before a counter step
  function automatic logic [PRE_W-1:0] prescale_last(ck_sel_e s);
    case (s)
      CK_DIV4: return PRE_W'(3);
      CK_DIV2: return PRE_W'(1);
      CK_DIV8: return PRE_W'(7);
      default: return PRE_W'(0);
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] hi_byte(logic [CNT_W-1:0] v);
    return v[CNT_W-1 -: BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] lo_byte(logic [CNT_W-1:0] v);
    return v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/capu_timebase.sv
module capu_timebase
  import capu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ck_sel_e          ck_sel_i,
  output logic [CNT_W-1:0] count_o
);
  logic [PRE_W-1:0] presc_q;
  logic             step;

  always_comb begin
    step = (ck_sel_i != CK_STOP) && (presc_q >= prescale_last(ck_sel_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      count_o <= '0;
    end else begin
      if (step)                     presc_q <= '0;
      else if (ck_sel_i != CK_STOP) presc_q <= presc_q + PRE_W'(1);
      count_o <= count_o + CNT_W'(step);
    end
  end
endmodule

// File: rtl/capu_channel.sv
module capu_channel
  import capu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             rise_sel_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             stat_rd_i,
  input  logic             hi_rd_i,
  input  logic             lo_acc_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             hold_o,
  output logic             take_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   sampled;
  logic                   edge_hit;
  logic                   live_take;
  logic                   wake_take;
  logic                   blocked;
  logic [CNT_W-1:0]       take_val;
  logic                   armed_q;
  logic [CNT_W-1:0]       pend_q;
  logic [CNT_W-1:0]       shadow_q;
  logic                   shadow_v_q;
  logic                   clr_arm_q;

  always_comb begin
    sampled   = sync_q[SYNC_STAGES-1];
    edge_hit  = rise_sel_i ? (sampled & ~prev_q) : (~sampled & prev_q);
    live_take = edge_hit & ~halt_i;
    wake_take = armed_q & ~halt_i;
    take_o    = live_take | wake_take;
    take_val  = live_take ? count_i : pend_q;
    blocked   = hold_o & ~lo_acc_i;
  end

  // synchronizer and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sampled;
    end
  end

  // halt arming: first valid edge only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= '0;
    end else if (halt_i) begin
      if (edge_hit && !armed_q) begin
        armed_q <= 1'b1;
        pend_q  <= count_i;
      end
    end else begin
      armed_q <= 1'b0;
    end
  end

  // capture register, shadow and byte coherence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_o      <= '0;
      shadow_q   <= '0;
      shadow_v_q <= 1'b0;
      hold_o     <= 1'b0;
    end else begin
      if (take_o) begin
        if (blocked) begin
          shadow_q   <= take_val;
          shadow_v_q <= 1'b1;
        end else begin
          cap_o      <= take_val;
          shadow_v_q <= 1'b0;
        end
      end else if (lo_acc_i && shadow_v_q) begin
        cap_o      <= shadow_q;
        shadow_v_q <= 1'b0;
      end
      if (lo_acc_i)     hold_o <= 1'b0;
      else if (hi_rd_i) hold_o <= 1'b1;
    end
  end

  // flag with two-step clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o    <= 1'b0;
      clr_arm_q <= 1'b0;
    end else begin
      if (stat_rd_i)     clr_arm_q <= flag_o;
      else if (lo_acc_i) clr_arm_q <= 1'b0;
      if (take_o)                     flag_o <= 1'b1;
      else if (lo_acc_i && clr_arm_q) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/capu_regfile.sv
module capu_regfile
  import capu_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_i,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [BYTE_W-1:0]             wdata_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  caps_i,
  input  logic [NUM_CH-1:0]             flags_i,
  output logic [BYTE_W-1:0]             rdata_o,
  output logic [NUM_CH-1:0]             rise_sel_o,
  output logic                          irq_en_o,
  output ck_sel_e                       ck_sel_o,
  output logic                          stat_rd_o,
  output logic [NUM_CH-1:0]             hi_rd_o,
  output logic [NUM_CH-1:0]             lo_acc_o
);
  localparam int IE_BIT = NUM_CH;
  localparam int CK_LSB = NUM_CH + 2;
  localparam logic [BYTE_W-1:0] CFG_MASK =
    BYTE_W'((1 << (NUM_CH + 1)) - 1) | BYTE_W'(3 << CK_LSB);

  logic [BYTE_W-1:0] cfg_q;
  logic              cfg_we;

  always_comb begin
    cfg_we     = sel_i && wr_i && (addr_i == ADDR_W'(0));
    stat_rd_o  = sel_i && !wr_i && (addr_i == ADDR_W'(1));
    rise_sel_o = cfg_q[NUM_CH-1:0];
    irq_en_o   = cfg_q[IE_BIT];
    ck_sel_o   = ck_sel_e'(cfg_q[CK_LSB +: 2]);
    for (int i = 0; i < NUM_CH; i++) begin
      hi_rd_o[i]  = sel_i && !wr_i && (addr_i == ADDR_W'(2 + 2 * i));
      lo_acc_o[i] = sel_i && (addr_i == ADDR_W'(3 + 2 * i));
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(0)) rdata_o = cfg_q;
    if (addr_i == ADDR_W'(1)) rdata_o = BYTE_W'(flags_i);
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(2 + 2 * i)) rdata_o = hi_byte(caps_i[i]);
      if (addr_i == ADDR_W'(3 + 2 * i)) rdata_o = lo_byte(caps_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= wdata_i & CFG_MASK;
  end
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
  import capu_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(2 + 2 * NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_i,
  input  logic               glob_mask_i,
  input  logic [NUM_CH-1:0]  cap_pin_i,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [BYTE_W-1:0]  bus_wdata_i,
  output logic [BYTE_W-1:0]  bus_rdata_o,
  output logic               irq_o,
  output logic [CNT_W-1:0]   count_o
);
  logic [NUM_CH-1:0][CNT_W-1:0] caps;
  logic [NUM_CH-1:0]            flags;
  logic [NUM_CH-1:0]            holds;
  logic [NUM_CH-1:0]            takes;
  logic [NUM_CH-1:0]            rise_sel;
  logic [NUM_CH-1:0]            hi_rd;
  logic [NUM_CH-1:0]            lo_acc;
  logic                         stat_rd;
  logic                         irq_en;
  ck_sel_e                      ck_sel;

  capu_timebase tb_u (
    .clk      (clk),
    .rst_n    (rst_n),
    .ck_sel_i (ck_sel),
    .count_o  (count_o)
  );

  capu_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) rf_u (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (bus_sel_i),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .caps_i     (caps),
    .flags_i    (flags),
    .rdata_o    (bus_rdata_o),
    .rise_sel_o (rise_sel),
    .irq_en_o   (irq_en),
    .ck_sel_o   (ck_sel),
    .stat_rd_o  (stat_rd),
    .hi_rd_o    (hi_rd),
    .lo_acc_o   (lo_acc)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    capu_channel #(.SYNC_STAGES(SYNC_STAGES)) ch_u (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (cap_pin_i[g]),
      .rise_sel_i (rise_sel[g]),
      .halt_i     (halt_i),
      .count_i    (count_o),
      .stat_rd_i  (stat_rd),
      .hi_rd_i    (hi_rd[g]),
      .lo_acc_i   (lo_acc[g]),
      .cap_o      (caps[g]),
      .flag_o     (flags[g]),
      .hold_o     (holds[g]),
      .take_o     (takes[g])
    );
  end

  always_comb begin
    irq_o = irq_en && !glob_mask_i && (|flags);
  end
endmodule

// File: rtl/capu_checker.sv
module capu_checker
  import capu_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         halt_i,
  input logic                         glob_mask_i,
  input logic                         irq_o,
  input logic [CNT_W-1:0]             count_o,
  input logic [1:0]                   ck_sel,
  input logic [NUM_CH-1:0]            flags,
  input logic [NUM_CH-1:0]            holds,
  input logic [NUM_CH-1:0]            lo_acc,
  input logic [NUM_CH-1:0]            takes,
  input logic [NUM_CH-1:0][CNT_W-1:0] caps
);
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    glob_mask_i |-> !irq_o); // R5
  AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq_o); // R5
  AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_sel == 2'b11) |=> $stable(count_o)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_o == $past(count_o) || count_o == $past(count_o) + CNT_W'(1))); // R2

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_HALT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |-> !takes[i]); // R9
    AST_FLAG_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      takes[i] |=> flags[i]); // R4
    AST_FLAG_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(lo_acc[i])); // R6
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (holds[i] && !lo_acc[i]) |=> $stable(caps[i])); // R8
  end
endmodule

bind dual_edge_capture capu_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .halt_i      (halt_i),
  .glob_mask_i (glob_mask_i),
  .irq_o       (irq_o),
  .count_o     (count_o),
  .ck_sel      (ck_sel),
  .flags       (flags),
  .holds       (holds),
  .lo_acc      (lo_acc),
  .takes       (takes),
  .caps        (caps)
);

// File: tb/dual_edge_capture_tb_top.sv
`timescale 1ns/1ps
module dual_edge_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_i = 1'b0;
  logic        glob_mask_i = 1'b0;
  logic [1:0]  cap_pin_i = 2'b00;
  logic        bus_sel_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [2:0]  bus_addr_i = 3'd0;
  logic [7:0]  bus_wdata_i = 8'd0;
  logic [7:0]  bus_rdata_o;
  logic        irq_o;
  logic [15:0] count_o;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic [1:0] rise_b = 2'b00;

  always #2.5 clk = ~clk;

  dual_edge_capture dut_i (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .glob_mask_i(glob_mask_i),
    .cap_pin_i(cap_pin_i), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .count_o(count_o)
  );

  function automatic int steps_in_32(int sel);
    case (sel)
      0: return 8;
      1: return 16;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] cfg_word(logic [1:0] rise, logic ie, logic [1:0] ck);
    return {2'b00, ck, 1'b0, ie, rise};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_sel_i = 1'b0;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic set_idle(input int ch);
    @(negedge clk);
    cap_pin_i[ch] = ~rise_b[ch];
    repeat (4) @(negedge clk);
  endtask

  // drive the active edge; return the counter value the capture must hold
  task automatic fire(input int ch, output logic [15:0] exp);
    @(negedge clk);
    cap_pin_i[ch] = rise_b[ch];
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    exp = count_o;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    logic [7:0] d;
    bus_rd(3'd1, d);
    bus_rd(3'd3, d);
    bus_rd(3'd5, d);
  endtask

  task automatic read_cap(input int ch, output logic [15:0] v);
    logic [7:0] h, l;
    bus_rd(3'(2 + 2 * ch), h);
    bus_rd(3'(3 + 2 * ch), l);
    v = {h, l};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] e1, e2, e3, eh, v, c0;
    int unsigned seed;
    seed = $urandom(32'h1D5E_2024);

    repeat (3) @(negedge clk);
    check("R1 count in reset", count_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", irq_o, 0);
    for (int a = 0; a < 6; a++) begin
      bus_rd(3'(a), d);
      check("R1 reg", d, 0);
    end

    // R2 counter rate for every clock-select value
    for (int s = 0; s < 4; s++) begin
      bus_wr(3'd0, cfg_word(2'b00, 1'b0, 2'(s)));
      repeat (16) @(negedge clk);
      c0 = count_o;
      repeat (32) @(negedge clk);
      check("R2 rate", 32'(count_o - c0), steps_in_32(s));
    end

    // randomized captures, R3 R4 R5 R6
    for (int it = 0; it < 24; it++) begin
      int ch;
      logic [1:0] ck;
      ch = int'($urandom % 2);
      ck = 2'($urandom % 3);
      rise_b = 2'($urandom);
      glob_mask_i = 1'($urandom);
      bus_wr(3'd0, cfg_word(rise_b, 1'b1, ck));
      @(negedge clk);
      cap_pin_i = ~rise_b;
      repeat (4) @(negedge clk);
      clear_all();
      bus_rd(3'd1, d);
      check("R6 flags cleared", d, 0);
      check("R5 irq idle", irq_o, 0);
      fire(ch, e1);
      bus_rd(3'd1, d);
      check("R4 flag set", d[ch], 1);
      check("R5 irq follows mask", irq_o, !glob_mask_i);
      read_cap(ch, v);
      check("R3 captured value", v, e1);
      bus_rd(3'd1, d);
      check("R6 flag cleared by sequence", d[ch], 0);
      set_idle(ch);
      bus_rd(3'd1, d);
      check("R3 opposite edge ignored", d[ch], 0);
      read_cap(ch, v);
      check("R3 opposite edge keeps value", v, e1);
    end

    // directed: channel 0 rising, div2, irq enabled, unmasked
    glob_mask_i = 1'b0;
    rise_b = 2'b01;
    bus_wr(3'd0, cfg_word(rise_b, 1'b1, 2'b01));
    @(negedge clk); cap_pin_i = 2'b10;
    repeat (4) @(negedge clk);
    clear_all();

    // R6: low-byte access without status read keeps the flag
    fire(0, e1);
    bus_rd(3'd3, d);
    bus_rd(3'd1, d);
    check("R6 no clear without status read", d[0], 1);
    bus_rd(3'd3, d);
    bus_rd(3'd1, d);
    check("R6 cleared after sequence", d[0], 0);

    // R7: flag set after the status read survives the low-byte access
    set_idle(0);
    bus_rd(3'd1, d);
    fire(0, e1);
    bus_wr(3'd3, 8'h5A);
    bus_rd(3'd1, d);
    check("R7 late flag survives", d[0], 1);
    clear_all();

    // R8: high-byte read freezes, shadow keeps the latest
    bus_rd(3'd2, d);
    check("R8 hi before freeze", d, e1[15:8]);
    set_idle(0);
    fire(0, e2);
    bus_rd(3'd2, d);
    check("R8 frozen hi", d, e1[15:8]);
    set_idle(0);
    fire(0, e3);
    bus_rd(3'd3, d);
    check("R8 unfreezing lo returns old", d, e1[7:0]);
    read_cap(0, v);
    check("R8 latest shadow loaded", v, e3);

    // R9: halt behaviour
    clear_all();
    set_idle(0);
    @(negedge clk); halt_i = 1'b1;
    fire(0, eh);
    set_idle(0);
    fire(0, e2);
    bus_rd(3'd1, d);
    check("R9 no flag in halt", d, 0);
    check("R9 no irq in halt", irq_o, 0);
    read_cap(0, v);
    check("R9 no transfer in halt", v, e3);
    @(negedge clk); halt_i = 1'b0;
    @(negedge clk);
    bus_rd(3'd1, d);
    check("R9 flag after wake", d[0], 1);
    read_cap(0, v);
    check("R9 first halt edge value", v, eh);

    // R10: writes to status and high byte have no effect
    clear_all();
    bus_wr(3'd1, 8'hFF);
    bus_rd(3'd1, d);
    check("R10 status write ignored", d, 0);
    bus_wr(3'd2, 8'hA5);
    bus_rd(3'd2, d);
    check("R10 hi write ignored", d, eh[15:8]);
    bus_rd(3'd3, d);

    report();
  end
endmodule